// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block works out where a single memory load or store goes and what the base register holds afterwards. It takes a 32-bit base value and an offset. The offset is either an immediate field or a register value shifted left by 0 to 31 bits, and it can be added to or subtracted from the base. From these inputs the block produces the effective address, the updated base value, a strobe that says the base must be written back, and a flag for an offset form that the access class does not allow.

Two indexing schemes are supported:

- **Pre-indexed:** the access uses base±offset. When writeback is requested, that same sum also becomes the new base.
- **Post-indexed:** the access uses the unmodified base, and the base is always updated to base±offset.

A plain access with no offset is written as pre-indexed with a zero immediate and no writeback.

There are two access classes:

- **Wide class (word / unsigned byte):** the full 12-bit immediate and scaled register offsets are both allowed.
- **Narrow class (halfword / signed):** only an 8-bit immediate is allowed, and the register offset cannot be shifted.

The address path is combinational and ends in one output register stage when `OUT_REG` is 1, which is the default. The block has no control sequence, so there are no states and no state transitions. The only sequential element is that output stage.

Top module: `lsagu_top`

## Requirements
- R1: With `sub_i`=0 and `post_i`=0, `ea_o` is `base_i` plus the offset. The offset is `imm_i` zero-extended when `use_reg_i`=0, and `reg_off_i` shifted left by `shamt_i` when `use_reg_i`=1. For example, base 0x4000 with register offset 0x20 and shift 2 gives 0x4080.
- R2: With `sub_i`=1 the offset is subtracted instead of added. All sums and differences wrap modulo 2^32.
- R3: Pre-indexed (`post_i`=0) with `wb_req_i`=1 and a legal offset sets `wb_valid_o`=1 and `new_base_o`=`ea_o`. With `wb_req_i`=0, `wb_valid_o` is 0.
- R4: Post-indexed (`post_i`=1) with a legal offset gives `ea_o`=`base_i`, `new_base_o`=base±offset and `wb_valid_o`=1, whatever the value of `wb_req_i`. For example, base 0x8000 with offset 4 gives `ea_o`=0x8000 and `new_base_o`=0x8004.
- R5: Pre-indexed with a zero immediate and no writeback gives `ea_o`=`new_base_o`=`base_i` and `wb_valid_o`=0.
- R6: `cls_i`=0 selects the wide class (word / unsigned byte). In this class any 12-bit immediate and any shift amount is accepted, and `illegal_o` stays 0.
- R7: `cls_i`=1 selects the narrow class (halfword / signed). In this class `illegal_o`=1 when a register offset has a shift amount other than zero, or when any of `imm_i` bits [11:8] is set on an immediate offset. An unshifted register offset is legal.
- R8: Whenever `illegal_o`=1, `wb_valid_o` is 0. Whenever `wb_valid_o`=0, `new_base_o` equals `base_i`.
- R9: With `OUT_REG`=1, the outputs show the result for the inputs sampled at a rising clock edge, starting just after that edge. While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low synchronous reset |
| base_i | input | 32 | Base register value |
| imm_i | input | 12 | Immediate offset field |
| reg_off_i | input | 32 | Register offset value |
| use_reg_i | input | 1 | 1 selects the register offset, 0 selects the immediate |
| shamt_i | input | 5 | Left shift applied to the register offset |
| sub_i | input | 1 | 1 subtracts the offset |
| post_i | input | 1 | 1 selects post-indexed, 0 selects pre-indexed |
| wb_req_i | input | 1 | Writeback request for pre-indexed mode |
| cls_i | input | 1 | Access class: 0 wide, 1 narrow |
| ea_o | output | 32 | Effective address |
| new_base_o | output | 32 | Updated base value |
| wb_valid_o | output | 1 | The base must be written back |
| illegal_o | output | 1 | Offset form not allowed for the class |

## Verification
Each result is due one clock after its inputs are presented. The bench changes the inputs on the falling edge. It samples all four outputs on the next falling edge, after exactly one rising edge has loaded the output register. The reset values are read while reset is held. The checks in the design compare each output with the inputs from one edge earlier, and they are gated until one clean edge has passed since reset.

// File: rtl/lsagu_pkg.sv
package lsagu_pkg;
    localparam int ADDR_W   = 32;
    localparam int IMM_W    = 12;
    localparam int NARROW_W = 8;
    localparam int SH_W     = 5;

    typedef enum logic {
        CLS_WIDE   = 1'b0,
        CLS_NARROW = 1'b1
    } acc_cls_e;
endpackage

// File: rtl/lsagu_offset.sv
module lsagu_offset #(
    parameter int W     = 32,
    parameter int IMM_W = 12,
    parameter int SH_W  = 5
) (
    input  logic [IMM_W-1:0] imm,
    input  logic [W-1:0]     reg_off,
    input  logic             use_reg,
    input  logic [SH_W-1:0]  shamt,
    output logic [W-1:0]     off
);
    localparam int PAD_W = W - IMM_W;

    always_comb begin
        if (use_reg) off = reg_off << shamt;
        else         off = {{PAD_W{1'b0}}, imm};
    end
endmodule

// File: rtl/lsagu_legal.sv
module lsagu_legal #(
    parameter int IMM_W    = 12,
    parameter int NARROW_W = 8,
    parameter int SH_W     = 5
) (
    input  lsagu_pkg::acc_cls_e cls,
    input  logic                use_reg,
    input  logic [SH_W-1:0]     shamt,
    input  logic [IMM_W-1:0]    imm,
    output logic                illegal
);
    localparam int HI_W = IMM_W - NARROW_W;

    logic imm_too_wide;
    logic scaled;

    assign imm_too_wide = !use_reg && (imm[IMM_W-1 -: HI_W] != '0);
    assign scaled       = use_reg && (shamt != '0);

    always_comb begin
        unique case (cls)
            lsagu_pkg::CLS_WIDE:   illegal = 1'b0;
            lsagu_pkg::CLS_NARROW: illegal = imm_too_wide || scaled;
            default:               illegal = 1'b0;
        endcase
    end
endmodule

// File: rtl/lsagu_adder.sv
module lsagu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] off,
    input  logic         sub,
    output logic [W-1:0] sum
);
    always_comb begin
        if (sub) sum = base - off;
        else     sum = base + off;
    end
endmodule

// File: rtl/lsagu_top.sv
module lsagu_top #(
    parameter int W        = lsagu_pkg::ADDR_W,
    parameter int IMM_W    = lsagu_pkg::IMM_W,
    parameter int NARROW_W = lsagu_pkg::NARROW_W,
    parameter int SH_W     = lsagu_pkg::SH_W,
    parameter bit OUT_REG  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     base_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [W-1:0]     reg_off_i,
    input  logic             use_reg_i,
    input  logic [SH_W-1:0]  shamt_i,
    input  logic             sub_i,
    input  logic             post_i,
    input  logic             wb_req_i,
    input  logic             cls_i,
    output logic [W-1:0]     ea_o,
    output logic [W-1:0]     new_base_o,
    output logic             wb_valid_o,
    output logic             illegal_o
);
    import lsagu_pkg::*;

    acc_cls_e    cls;
    logic [W-1:0] off;
    logic [W-1:0] sum;
    logic         illegal_c;
    logic         wbv_c;
    logic [W-1:0] ea_c;
    logic [W-1:0] nb_c;

    assign cls = acc_cls_e'(cls_i);

    lsagu_offset #(.W(W), .IMM_W(IMM_W), .SH_W(SH_W)) u_off (
        .imm(imm_i), .reg_off(reg_off_i), .use_reg(use_reg_i),
        .shamt(shamt_i), .off(off)
    );

    lsagu_legal #(.IMM_W(IMM_W), .NARROW_W(NARROW_W), .SH_W(SH_W)) u_legal (
        .cls(cls), .use_reg(use_reg_i), .shamt(shamt_i),
        .imm(imm_i), .illegal(illegal_c)
    );

    lsagu_adder #(.W(W)) u_add (
        .base(base_i), .off(off), .sub(sub_i), .sum(sum)
    );

    always_comb begin
        wbv_c = !illegal_c && (post_i || wb_req_i);
        ea_c  = post_i ? base_i : sum;
        nb_c  = wbv_c ? sum : base_i;
    end

    generate
        if (OUT_REG) begin : g_reg
            logic live_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ea_o       <= '0;
                    new_base_o <= '0;
                    wb_valid_o <= 1'b0;
                    illegal_o  <= 1'b0;
                    live_q     <= 1'b0;
                end else begin
                    ea_o       <= ea_c;
                    new_base_o <= nb_c;
                    wb_valid_o <= wbv_c;
                    illegal_o  <= illegal_c;
                    live_q     <= 1'b1;
                end
            end

            a_r8_illegal_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
                illegal_o |-> !wb_valid_o);
            a_r4_post_ea_base: assert property (@(posedge clk) disable iff (!rst_n)
                (live_q && $past(post_i)) |-> (ea_o == $past(base_i)));
            a_r4_post_always_wb: assert property (@(posedge clk) disable iff (!rst_n)
                (live_q && $past(post_i) && !illegal_o) |-> wb_valid_o);
            a_r3_pre_wb_equal: assert property (@(posedge clk) disable iff (!rst_n)
                (live_q && wb_valid_o && !$past(post_i)) |-> (new_base_o == ea_o));
            a_r8_hold_base: assert property (@(posedge clk) disable iff (!rst_n)
                (live_q && !wb_valid_o) |-> (new_base_o == $past(base_i)));
            a_r6_wide_legal: assert property (@(posedge clk) disable iff (!rst_n)
                (live_q && !$past(cls_i)) |-> !illegal_o);
        end else begin : g_comb
            always_comb begin
                ea_o       = ea_c;
                new_base_o = nb_c;
                wb_valid_o = wbv_c;
                illegal_o  = illegal_c;
            end
        end
    endgenerate
endmodule

// File: tb/lsagu_top_tb_top.sv
module lsagu_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] base_i = '0;
    logic [11:0] imm_i = '0;
    logic [31:0] reg_off_i = '0;
    logic        use_reg_i = 1'b0;
    logic [4:0]  shamt_i = '0;
    logic        sub_i = 1'b0, post_i = 1'b0, wb_req_i = 1'b0, cls_i = 1'b0;
    logic [31:0] ea_o, new_base_o;
    logic        wb_valid_o, illegal_o;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsagu_top dut_i (
        .clk(clk), .rst_n(rst_n), .base_i(base_i), .imm_i(imm_i),
        .reg_off_i(reg_off_i), .use_reg_i(use_reg_i), .shamt_i(shamt_i),
        .sub_i(sub_i), .post_i(post_i), .wb_req_i(wb_req_i), .cls_i(cls_i),
        .ea_o(ea_o), .new_base_o(new_base_o), .wb_valid_o(wb_valid_o),
        .illegal_o(illegal_o)
    );

    function automatic void model(
        input  logic [31:0] b, input logic [11:0] im, input logic [31:0] ro,
        input  logic ur, input logic [4:0] sh, input logic sb, input logic po,
        input  logic wr, input logic cl,
        output logic [31:0] ea, output logic [31:0] nb,
        output logic wv, output logic il);
        logic [31:0] o, s;
        o  = ur ? (ro << sh) : {20'd0, im};
        s  = sb ? b - o : b + o;
        il = cl && ((ur && sh != 0) || (!ur && im[11:8] != 0));
        wv = !il && (po || wr);
        ea = po ? b : s;
        nb = wv ? s : b;
    endfunction

    task automatic apply_and_check(
        input logic [31:0] b, input logic [11:0] im, input logic [31:0] ro,
        input logic ur, input logic [4:0] sh, input logic sb, input logic po,
        input logic wr, input logic cl, input string req);
        logic [31:0] xe, xn;
        logic xw, xi;
        @(negedge clk);
        base_i = b; imm_i = im; reg_off_i = ro; use_reg_i = ur; shamt_i = sh;
        sub_i = sb; post_i = po; wb_req_i = wr; cls_i = cl;
        model(b, im, ro, ur, sh, sb, po, wr, cl, xe, xn, xw, xi);
        @(negedge clk);
        n_checks++;
        if (ea_o !== xe || new_base_o !== xn || wb_valid_o !== xw || illegal_o !== xi) begin
            n_fail++;
            $display("FAIL %s: got ea=%h nb=%h wv=%b il=%b expected ea=%h nb=%h wv=%b il=%b",
                     req, ea_o, new_base_o, wb_valid_o, illegal_o, xe, xn, xw, xi);
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R9: outputs are zero while reset is held
        n_checks++;
        if (ea_o !== 0 || new_base_o !== 0 || wb_valid_o !== 0 || illegal_o !== 0) begin
            n_fail++;
            $display("FAIL R9: got ea=%h nb=%h wv=%b il=%b expected all zero",
                     ea_o, new_base_o, wb_valid_o, illegal_o);
        end
        rst_n = 1'b1;

        // R1 scaled register example
        apply_and_check(32'h4000, 12'h0, 32'h20, 1, 5'd2, 0, 0, 0, 0, "R1");
        // R4 post-index example
        apply_and_check(32'h8000, 12'h4, 32'h0, 0, 5'd0, 0, 1, 0, 0, "R4");
        // R2 subtract with writeback, and wrap below zero
        apply_and_check(32'h9000, 12'h1, 32'h0, 0, 5'd0, 1, 0, 1, 0, "R2");
        apply_and_check(32'h0000_0002, 12'h5, 32'h0, 0, 5'd0, 1, 0, 1, 0, "R2");
        apply_and_check(32'hFFFF_FFF0, 12'h20, 32'h0, 0, 5'd0, 0, 0, 1, 0, "R2");
        // R3 pre-index with and without writeback
        apply_and_check(32'h1000, 12'h10, 32'h0, 0, 5'd0, 0, 0, 1, 0, "R3");
        apply_and_check(32'h1000, 12'h10, 32'h0, 0, 5'd0, 0, 0, 0, 0, "R3");
        // R5 zero offset
        apply_and_check(32'hABCD_0000, 12'h0, 32'h0, 0, 5'd0, 0, 0, 0, 0, "R5");
        // R6 wide class: full immediate and shift 31
        apply_and_check(32'h10, 12'hFFF, 32'h0, 0, 5'd0, 0, 0, 1, 0, "R6");
        apply_and_check(32'h10, 12'h0, 32'h3, 1, 5'd31, 0, 1, 0, 0, "R6");
        // R7 narrow class rules
        apply_and_check(32'h2000, 12'h0FF, 32'h0, 0, 5'd0, 0, 0, 1, 1, "R7");
        apply_and_check(32'h2000, 12'h100, 32'h0, 0, 5'd0, 0, 0, 1, 1, "R7");
        apply_and_check(32'h2000, 12'h0, 32'h8, 1, 5'd1, 0, 1, 0, 1, "R7");
        apply_and_check(32'h2000, 12'h0, 32'h8, 1, 5'd0, 1, 1, 0, 1, "R7");
        // R8 illegal post-index keeps the base
        apply_and_check(32'h3000, 12'h800, 32'h0, 0, 5'd0, 0, 1, 1, 1, "R8");

        for (int i = 0; i < 400; i++) begin
            logic [31:0] b, ro;
            logic [11:0] im;
            logic [4:0] sh;
            logic ur, sb, po, wr, cl;
            string rq;
            b = $urandom(); ro = $urandom(); im = 12'($urandom());
            sh = 5'($urandom()); ur = 1'($urandom()); sb = 1'($urandom());
            po = 1'($urandom()); wr = 1'($urandom()); cl = 1'($urandom());
            if ($urandom_range(0, 3) == 0) sh = 5'd0;
            if (cl && ((ur && sh != 0) || (!ur && im[11:8] != 0))) rq = "R7";
            else if (po) rq = "R4";
            else rq = "R3";
            apply_and_check(b, im, ro, ur, sh, sb, po, wr, cl, rq);
        end

        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule